// File: doc/BRIEF.md
# Opcode Class Decoder for an 8-bit Accumulator Processor

This block turns each fetched opcode byte of a small 8-bit accumulator processor into a registered decode record. The record holds the instruction class, the operand fields taken from fixed bit positions of the byte, and a flag for each side of the operation that goes to memory through the HL pointer instead of a register. It also holds the number of machine cycles the instruction takes. The register file, ALU, bus and flag logic sit outside the block. The fetch logic gives the result of the branch condition together with the byte, and the block uses it to choose between the taken and the untaken cycle count.

The byte 0xCB is not an instruction on its own. It marks the next byte as an extended bit-manipulation operation. A two-state sequencer notes the marker, produces no record for it, and decodes the following byte in the extended table. In that table the top two bits choose the operation group. Every group except bit test writes its result back to its operand.

Top module: `opdec_top`

## Requirements
- R1: Field outputs come from the decoded byte: `reg_lo` = bits [2:0], `reg_hi` = bits [5:3], `alu_op` = bits [5:3], `pair_idx` = bits [5:4], `cc` = bits [4:3], and `rst_vec` = the byte ANDed with 0x38, zero-extended to 16 bits.
- R2: `iclass` codes for unprefixed bytes, checked in this order:
  - 1 for a load between registers (bits [7:6]=01).
  - 2 for an 8-bit immediate load ((b&0xC7)=0x06).
  - 3 for a 16-bit immediate load ((b&0xCF)=0x01).
  - 4 for push ((b&0xCF)=0xC5) and 5 for pop ((b&0xCF)=0xC1).
  - 6 for ALU with a register source (bits [7:6]=10) and 7 for ALU with an immediate ((b&0xC7)=0xC6).
  - 8 for 8-bit increment or decrement ((b&0xC6)=0x04) and 9 for pair increment or decrement ((b&0xC7)=0x03).
  - 10 for adding a pair to HL ((b&0xCF)=0x09).
  - 11 for the conditional absolute jump ((b&0xE7)=0xC2), 12 for the conditional relative jump ((b&0xE7)=0x20), 13 for the conditional call ((b&0xE7)=0xC4) and 14 for the conditional return ((b&0xE7)=0xC0).
  - 15 for restart ((b&0xC7)=0xC7).
  - 16 for any byte that follows the prefix.
- R3: The byte 0x76 is never decoded as a load. It gets class 0.
- R4: `hl_src` is 1 when `reg_lo`=6 for classes 1, 6 and 16. `hl_dst` is 1 when `reg_hi`=6 for classes 1, 2 and 8. `hl_dst` is also 1 for class 16 when `reg_lo`=6 and `cb_wb`=1. Both flags are 0 in every other case.
- R5: Unconditional cycle counts:
  - Class 1: 1, or 2 when either side is HL.
  - Class 2: 2, or 3 when the destination is HL.
  - Class 3: 3.
  - Classes 4, 5 and 15: 4.
  - Class 6: 1, or 2 with an HL source.
  - Classes 7, 9 and 10: 2.
  - Class 8: 1, or 3 on HL.
- R6: Conditional cycle counts, written as taken/untaken: jump 4/3, relative jump 3/2, call 6/3 and return 5/2. `cond_met` sampled with the byte selects the taken count.
- R7: `pair_af` is 1 only for classes 4 and 5 when `pair_idx`=3.
- R8: `dec_down` equals bit 3 for class 9 and bit 0 for class 8. It is 0 for every other class.
- R9: An unprefixed 0xCB sets `pfx_wait`, and `dec_valid` stays 0 in the next cycle. The next accepted byte, including another 0xCB, is decoded as class 16 and clears `pfx_wait`.
- R10: For class 16, `cb_group` = bits [7:6] and `cb_wb` = (group != 01). The cycle count is 2 on a register, 3 for an HL read without write-back, and 4 for HL with write-back. For unprefixed bytes `cb_group` and `cb_wb` are 0.
- R11: A byte that matches no class gives class 0, `illegal`=1 and a cycle count of 1.
- R12: All outputs are registered. `dec_valid` pulses in the cycle after an accepted byte. With `op_valid` low, `dec_valid` is 0 and the record holds its value. After reset every output is 0.
- R13: `cond_met` has no effect on any class other than 11 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Fetched byte present this cycle |
| op_byte | input | 8 | Fetched opcode byte |
| cond_met | input | 1 | Branch condition result for this byte |
| dec_valid | output | 1 | Decode record updated |
| pfx_wait | output | 1 | Prefix seen, waiting for the second byte |
| iclass | output | 5 | Instruction class code |
| illegal | output | 1 | Byte matched no class |
| reg_lo | output | 3 | Low register index |
| reg_hi | output | 3 | High register index or bit number |
| pair_idx | output | 2 | Register pair index |
| alu_op | output | 3 | ALU operation |
| cc | output | 2 | Condition code |
| rst_vec | output | 16 | Restart target address |
| hl_src | output | 1 | Source operand is memory at HL |
| hl_dst | output | 1 | Destination operand is memory at HL |
| pair_af | output | 1 | Pair 3 means accumulator and flags |
| dec_down | output | 1 | Increment or decrement is a decrement |
| cb_group | output | 2 | Extended operation group |
| cb_wb | output | 1 | Extended operation writes back |
| mcycles | output | 3 | Machine-cycle count |

## Verification
Two functions can act on the same byte: the prefix sequencer and the primary class table. The second byte of a prefixed pair may itself be 0xCB, or it may look like a conditional branch with `cond_met` high. The bench sweeps all 256 second bytes after a prefix, each with `cond_met` set from the byte's lowest bit. Every one of them must come out as class 16, with extended-table cycles and no second prefix wait. The bench also sweeps all 256 primary bytes with the condition low and then high. It compares each whole record against a model built independently from the field positions in the requirements.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int OP_W  = 8;
  localparam int VEC_W = 16;
  localparam int CYC_W = 3;
  localparam int CLS_W = 5;

  typedef enum logic [CLS_W-1:0] {
    C_ILL     = 5'd0,
    C_LD8     = 5'd1,
    C_LD8I    = 5'd2,
    C_LD16I   = 5'd3,
    C_PUSH    = 5'd4,
    C_POP     = 5'd5,
    C_ALUR    = 5'd6,
    C_ALUI    = 5'd7,
    C_INCDEC8 = 5'd8,
    C_INCDEC16= 5'd9,
    C_ADDHL   = 5'd10,
    C_JPCC    = 5'd11,
    C_JRCC    = 5'd12,
    C_CALLCC  = 5'd13,
    C_RETCC   = 5'd14,
    C_RST     = 5'd15,
    C_CBOP    = 5'd16
  } iclass_e;

  typedef struct packed {
    iclass_e           cls;
    logic              illegal;
    logic [2:0]        reg_lo;
    logic [2:0]        reg_hi;
    logic [1:0]        pair;
    logic [2:0]        alu;
    logic [1:0]        cc;
    logic [VEC_W-1:0]  rst_vec;
    logic              hl_src;
    logic              hl_dst;
    logic              pair_af;
    logic              down;
    logic [1:0]        cb_group;
    logic              cb_wb;
    logic [CYC_W-1:0]  cycles;
  } decode_t;

endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic [OP_W-1:0] op,
  output logic [2:0]      f_lo,
  output logic [2:0]      f_hi,
  output logic [1:0]      f_pair,
  output logic [1:0]      f_cc,
  output logic [VW-1:0]   f_rst
);
  localparam logic [OP_W-1:0] RST_MASK = 8'h38;

  always_comb begin
    f_lo   = op[2:0];
    f_hi   = op[5:3];
    f_pair = op[5:4];
    f_cc   = op[4:3];
    f_rst  = '0;
    f_rst[OP_W-1:0] = op & RST_MASK;
  end
endmodule

// File: rtl/opdec_class.sv
module opdec_class
  import opdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            prefixed,
  input  logic            cond_met,
  output decode_t         d
);
  logic [2:0]       f_lo, f_hi;
  logic [1:0]       f_pair, f_cc;
  logic [VEC_W-1:0] f_rst;
  iclass_e          cls;
  logic             lo_hl, hi_hl, wb;
  logic [CYC_W-1:0] cyc;

  opdec_fields #(.VW(VEC_W)) u_fields (
    .op(op), .f_lo(f_lo), .f_hi(f_hi), .f_pair(f_pair),
    .f_cc(f_cc), .f_rst(f_rst)
  );

  // Class match; order of tests follows the decode priority.
  always_comb begin
    cls = C_ILL;
    if (prefixed)                                   cls = C_CBOP;
    else if (op[7:6] == 2'b01 && op != 8'h76)       cls = C_LD8;
    else if ((op & 8'hC7) == 8'h06)                 cls = C_LD8I;
    else if ((op & 8'hCF) == 8'h01)                 cls = C_LD16I;
    else if ((op & 8'hCF) == 8'hC5)                 cls = C_PUSH;
    else if ((op & 8'hCF) == 8'hC1)                 cls = C_POP;
    else if (op[7:6] == 2'b10)                      cls = C_ALUR;
    else if ((op & 8'hC7) == 8'hC6)                 cls = C_ALUI;
    else if ((op & 8'hC6) == 8'h04)                 cls = C_INCDEC8;
    else if ((op & 8'hC7) == 8'h03)                 cls = C_INCDEC16;
    else if ((op & 8'hE7) == 8'hC2)                 cls = C_JPCC;
    else if ((op & 8'hE7) == 8'h20)                 cls = C_JRCC;
    else if ((op & 8'hE7) == 8'hC4)                 cls = C_CALLCC;
    else if ((op & 8'hCF) == 8'h09)                 cls = C_ADDHL;
    else if ((op & 8'hE7) == 8'hC0)                 cls = C_RETCC;
    else if ((op & 8'hC7) == 8'hC7)                 cls = C_RST;
  end

  assign lo_hl = (f_lo == 3'd6);
  assign hi_hl = (f_hi == 3'd6);
  assign wb    = prefixed && (op[7:6] != 2'b01);

  // Machine-cycle table.
  always_comb begin
    unique case (cls)
      C_LD8:      cyc = (lo_hl || hi_hl) ? 3'd2 : 3'd1;
      C_LD8I:     cyc = hi_hl ? 3'd3 : 3'd2;
      C_LD16I:    cyc = 3'd3;
      C_PUSH,
      C_POP,
      C_RST:      cyc = 3'd4;
      C_ALUR:     cyc = lo_hl ? 3'd2 : 3'd1;
      C_ALUI,
      C_INCDEC16,
      C_ADDHL:    cyc = 3'd2;
      C_INCDEC8:  cyc = hi_hl ? 3'd3 : 3'd1;
      C_JPCC:     cyc = cond_met ? 3'd4 : 3'd3;
      C_JRCC:     cyc = cond_met ? 3'd3 : 3'd2;
      C_CALLCC:   cyc = cond_met ? 3'd6 : 3'd3;
      C_RETCC:    cyc = cond_met ? 3'd5 : 3'd2;
      C_CBOP:     cyc = !lo_hl ? 3'd2 : (wb ? 3'd4 : 3'd3);
      default:    cyc = 3'd1;
    endcase
  end

  always_comb begin
    d          = '0;
    d.cls      = cls;
    d.illegal  = (cls == C_ILL);
    d.reg_lo   = f_lo;
    d.reg_hi   = f_hi;
    d.pair     = f_pair;
    d.alu      = f_hi;
    d.cc       = f_cc;
    d.rst_vec  = f_rst;
    d.hl_src   = lo_hl && (cls == C_LD8 || cls == C_ALUR || cls == C_CBOP);
    d.hl_dst   = (hi_hl && (cls == C_LD8 || cls == C_LD8I || cls == C_INCDEC8))
              || (cls == C_CBOP && wb && lo_hl);
    d.pair_af  = (cls == C_PUSH || cls == C_POP) && (f_pair == 2'd3);
    d.down     = (cls == C_INCDEC16) ? op[3] :
                 (cls == C_INCDEC8)  ? op[0] : 1'b0;
    d.cb_group = prefixed ? op[7:6] : 2'b00;
    d.cb_wb    = wb;
    d.cycles   = cyc;
  end
endmodule

// File: rtl/opdec_seq.sv
module opdec_seq
  import opdec_pkg::*;
#(
  parameter logic [OP_W-1:0] PREFIX_CODE = 8'hCB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  input  decode_t         d_in,
  output logic            pfx_q,
  output logic            valid_q,
  output decode_t         d_q
);
  typedef enum logic { S_IDLE = 1'b0, S_PFX = 1'b1 } st_e;

  st_e  st_q, st_d;
  logic load;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    if (op_valid) begin
      if (st_q == S_IDLE && op_byte == PREFIX_CODE) begin
        st_d = S_PFX;
      end else begin
        st_d = S_IDLE;
        load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= d_in;
  end

  assign pfx_q = (st_q == S_PFX);

  p_pfx_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !pfx_q && op_byte == PREFIX_CODE) |=> (pfx_q && !valid_q));
  p_pfx_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pfx_q) |=> (!pfx_q && valid_q && d_q.cls == C_CBOP));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!valid_q && $stable(d_q) && $stable(pfx_q)));
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter logic [7:0] PREFIX_CODE = 8'hCB,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  input  logic        cond_met,
  output logic        dec_valid,
  output logic        pfx_wait,
  output logic [4:0]  iclass,
  output logic        illegal,
  output logic [2:0]  reg_lo,
  output logic [2:0]  reg_hi,
  output logic [1:0]  pair_idx,
  output logic [2:0]  alu_op,
  output logic [1:0]  cc,
  output logic [15:0] rst_vec,
  output logic        hl_src,
  output logic        hl_dst,
  output logic        pair_af,
  output logic        dec_down,
  output logic [1:0]  cb_group,
  output logic        cb_wb,
  output logic [2:0]  mcycles
);
  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic    rst_int_n;
  logic    pfx_q, valid_q;
  decode_t d_comb, d_q;

  // Reset: asserted asynchronously, released after SYNC_STAGES edges.
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= 1'b1;
      end
      assign rst_int_n = s_q;
    end else begin : g_syncn
      logic [SYNC_LAST:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_LAST-1:0], 1'b1};
      end
      assign rst_int_n = s_q[SYNC_LAST];
    end
  endgenerate

  opdec_class u_class (
    .op(op_byte), .prefixed(pfx_q), .cond_met(cond_met), .d(d_comb)
  );

  opdec_seq #(.PREFIX_CODE(PREFIX_CODE)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .op_valid(op_valid), .op_byte(op_byte),
    .d_in(d_comb), .pfx_q(pfx_q), .valid_q(valid_q), .d_q(d_q)
  );

  assign dec_valid = valid_q;
  assign pfx_wait  = pfx_q;
  assign iclass    = d_q.cls;
  assign illegal   = d_q.illegal;
  assign reg_lo    = d_q.reg_lo;
  assign reg_hi    = d_q.reg_hi;
  assign pair_idx  = d_q.pair;
  assign alu_op    = d_q.alu;
  assign cc        = d_q.cc;
  assign rst_vec   = d_q.rst_vec;
  assign hl_src    = d_q.hl_src;
  assign hl_dst    = d_q.hl_dst;
  assign pair_af   = d_q.pair_af;
  assign dec_down  = d_q.down;
  assign cb_group  = d_q.cb_group;
  assign cb_wb     = d_q.cb_wb;
  assign mcycles   = d_q.cycles;

  p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec_valid && illegal) |-> (iclass == 5'd0 && mcycles == 3'd1));
  p_pair_af_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec_valid && pair_af) |-> (pair_idx == 2'd3 && (iclass == 5'd4 || iclass == 5'd5)));
  p_cb_wb_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec_valid && iclass == 5'd16) |-> (cb_wb == (cb_group != 2'b01)));
  p_cycles_range_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_valid |-> (mcycles >= 3'd1 && mcycles <= 3'd6));
  p_no_load_76_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !pfx_wait && op_byte == 8'h76) |=> (iclass != 5'd1));
endmodule

// File: tb/tb_opdec_top.sv
module tb_opdec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic        cond_met = 1'b0;
  logic        dec_valid, pfx_wait, illegal, hl_src, hl_dst, pair_af, dec_down, cb_wb;
  logic [4:0]  iclass;
  logic [2:0]  reg_lo, reg_hi, alu_op, mcycles;
  logic [1:0]  pair_idx, cc, cb_group;
  logic [15:0] rst_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opdec_top dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .cond_met(cond_met), .dec_valid(dec_valid), .pfx_wait(pfx_wait),
    .iclass(iclass), .illegal(illegal), .reg_lo(reg_lo), .reg_hi(reg_hi),
    .pair_idx(pair_idx), .alu_op(alu_op), .cc(cc), .rst_vec(rst_vec),
    .hl_src(hl_src), .hl_dst(hl_dst), .pair_af(pair_af), .dec_down(dec_down),
    .cb_group(cb_group), .cb_wb(cb_wb), .mcycles(mcycles)
  );

  typedef logic [44:0] rec_t;

  function automatic rec_t actual();
    return {iclass, illegal, reg_lo, reg_hi, pair_idx, alu_op, cc, rst_vec,
            hl_src, hl_dst, pair_af, dec_down, cb_group, cb_wb, mcycles};
  endfunction

  // Model from the requirements, written on the x/y/z split of the byte.
  function automatic rec_t model(input logic [7:0] b, input bit pfx, input bit cm);
    logic [1:0] x = b[7:6];
    logic [2:0] y = b[5:3];
    logic [2:0] z = b[2:0];
    int cls = 0, cyc = 1;
    bit hs = 0, hd = 0, af = 0, dn = 0, wb = 0;
    logic [1:0] grp = 2'b00;
    if (pfx) begin
      cls = 16; grp = x; wb = (x != 2'b01);
      hs = (z == 6); hd = (z == 6) && wb;
      cyc = (z != 6) ? 2 : (wb ? 4 : 3);
    end else if (x == 0) begin
      if (z == 1 && !y[0]) begin cls = 3; cyc = 3; end
      else if (z == 1)     begin cls = 10; cyc = 2; end
      else if (z == 3)     begin cls = 9; cyc = 2; dn = y[0]; end
      else if (z == 4 || z == 5) begin
        cls = 8; dn = (z == 5); hd = (y == 6); cyc = hd ? 3 : 1;
      end
      else if (z == 6)     begin cls = 2; hd = (y == 6); cyc = hd ? 3 : 2; end
      else if (z == 0 && y >= 4) begin cls = 12; cyc = cm ? 3 : 2; end
    end else if (x == 1) begin
      if (!(y == 6 && z == 6)) begin
        cls = 1; hs = (z == 6); hd = (y == 6); cyc = (hs || hd) ? 2 : 1;
      end
    end else if (x == 2) begin
      cls = 6; hs = (z == 6); cyc = hs ? 2 : 1;
    end else begin
      if (z == 0 && y < 4)         begin cls = 14; cyc = cm ? 5 : 2; end
      else if (z == 1 && !y[0])    begin cls = 5; cyc = 4; af = (y[2:1] == 3); end
      else if (z == 2 && y < 4)    begin cls = 11; cyc = cm ? 4 : 3; end
      else if (z == 4 && y < 4)    begin cls = 13; cyc = cm ? 6 : 3; end
      else if (z == 5 && !y[0])    begin cls = 4; cyc = 4; af = (y[2:1] == 3); end
      else if (z == 6)             begin cls = 7; cyc = 2; end
      else if (z == 7)             begin cls = 15; cyc = 4; end
    end
    return {cls[4:0], (cls == 0), z, y, y[2:1], y, y[1:0], 8'h00, (b & 8'h38),
            hs, hd, af, dn, grp, wb, cyc[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input rec_t act, input rec_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b, input bit cm);
    @(negedge clk);
    op_valid = 1'b1; op_byte = b; cond_met = cm;
    @(negedge clk);
    op_valid = 1'b0; cond_met = ~cm;
  endtask

  initial begin
    rec_t e;
    rec_t keep;
    repeat (3) @(negedge clk);
    check(dec_valid == 0 && pfx_wait == 0 && actual() == '0, "R12 reset",
          {dec_valid, pfx_wait, actual()}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dec_valid == 0 && actual() == '0, "R12 after reset", actual(), '0);

    // Primary table, condition low then high.
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 256; i++) begin
        if (i == 8'hCB) continue;
        issue(i[7:0], c[0]);
        e = model(i[7:0], 0, c[0]);
        check(dec_valid && !pfx_wait && actual() == e,
              "R1 R2 R4 R5 R6 R7 R8 R11 R13 primary", actual(), e);
      end
    end

    // Dedicated points.
    issue(8'h76, 1'b0);
    check(iclass == 5'd0 && illegal && mcycles == 3'd1, "R3 byte 76",
          actual(), model(8'h76, 0, 0));
    issue(8'hC4, 1'b1);
    check(mcycles == 3'd6, "R6 call taken", actual(), model(8'hC4, 0, 1));
    issue(8'hC4, 1'b0);
    check(mcycles == 3'd3, "R6 call untaken", actual(), model(8'hC4, 0, 0));
    issue(8'h86, 1'b1);
    check(mcycles == 3'd2 && hl_src, "R13 cond ignored alu", actual(), model(8'h86, 0, 0));
    issue(8'hF5, 1'b0);
    check(pair_af && iclass == 5'd4, "R7 push af", actual(), model(8'hF5, 0, 0));
    issue(8'h3B, 1'b0);
    check(dec_down && iclass == 5'd9, "R8 pair decrement", actual(), model(8'h3B, 0, 0));
    issue(8'hFF, 1'b0);
    check(rst_vec == 16'h0038, "R1 restart vector", actual(), model(8'hFF, 0, 0));

    // Idle hold.
    keep = actual();
    @(negedge clk);
    check(!dec_valid && actual() == keep, "R12 hold idle", actual(), keep);

    // Prefixed table; second byte may collide with primary codes or the prefix.
    for (int i = 0; i < 256; i++) begin
      issue(8'hCB, 1'b1);
      check(pfx_wait && !dec_valid, "R9 prefix wait", {pfx_wait, dec_valid}, 2'b10);
      issue(i[7:0], i[0]);
      e = model(i[7:0], 1, i[0]);
      check(dec_valid && !pfx_wait && actual() == e, "R9 R10 prefixed",
            actual(), e);
    end

    issue(8'hCB, 1'b0);
    issue(8'h46, 1'b0);
    check(mcycles == 3'd3 && !cb_wb && !hl_dst && hl_src, "R10 bit test HL",
          actual(), model(8'h46, 1, 0));
    issue(8'hCB, 1'b0);
    issue(8'hC6, 1'b0);
    check(mcycles == 3'd4 && cb_wb && hl_dst, "R10 set HL", actual(), model(8'hC6, 1, 0));
    issue(8'hCB, 1'b0);
    issue(8'hCB, 1'b1);
    check(iclass == 5'd16 && !pfx_wait && reg_lo == 3'd3 && cb_group == 2'b11,
          "R9 double prefix", actual(), model(8'hCB, 1, 1));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule